// File: doc/BRIEF.md
# Eight-Column Block Write Engine

This engine turns one write command into column write strobes and bit enables for a 32-bit-wide memory row. When the special-function pin is high during a write, the command is a block write. It writes up to eight neighbouring columns at once, starting from an 8-column-aligned base. The written value is not taken from the data bus. It comes from a stored color register. During a block write the data bus instead chooses, byte by byte, which of the eight columns each byte lands in. When the special-function pin is low, the command is an ordinary single-column write of the bus data.

Both kinds of write can be gated further in two ways. A per-bit mask applies when write-per-bit is switched on for the bank. A 4-bit byte mask drops whole bytes. A separate command loads the color register from the data bus.

Block writes must be spaced by a cycle time given in clocks. A block write that comes too soon is refused and flagged. All results appear on registered outputs one clock after the command.

Top module: `blkwr_engine`

## Requirements
- R1: While reset is held and right after it, every strobe, enable, base, data and reject output is zero, and `busy` is low.
- R2: `cmd_op` = 2 (load color) stores `dq` in the color register. Every later accepted block write drives that value on `wr_data`, until the next load.
- R3: `cmd_op` = 1 (write) with `sfn` = 1 is a block write. Bit i of column k is enabled when `dq[8*(i/8)+k]` is 1, subject to R5 and R6. Column k's 32 enables sit at `col_bit_en[32*k +: 32]`.
- R4: For any issued write, `col_base` equals `col_addr` with its three lowest bits cleared.
- R5: `byte_mask[b]` = 1 clears bits 8b..8b+7 in all eight columns.
- R6: With `wpb_on` = 1, bit i is enabled only where `bit_mask[i]` = 1. With `wpb_on` = 0, `bit_mask` has no effect.
- R7: `cmd_op` = 1 with `sfn` = 0 is a normal write. It can enable only column `col_addr[2:0]`, with every non-masked bit on (subject to R5 and R6). `wr_data` equals `dq`.
- R8: `col_we[k]` is high exactly when at least one enable bit of column k is high.
- R9: An accepted block write holds `busy` high for TBWC-1 cycles after it. A block write that arrives while `busy` is high pulses `wr_reject` and gives no strobes.
- R10: Every write is a single access: the outputs of a command last one cycle, and the cycle after a no-op (`cmd_op` = 0) carries no strobes.
- R11: Normal writes are accepted while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 2 | 0 no-op, 1 write, 2 load color |
| col_addr | input | COL_W | Column address of the write |
| sfn | input | 1 | Special-function pin: 1 selects block write |
| dq | input | 32 | Write data, color load data, or per-byte column select |
| byte_mask | input | 4 | 1 suppresses the byte |
| wpb_on | input | 1 | Write-per-bit enabled for the target bank |
| bit_mask | input | 32 | Per-bit mask, 1 lets the bit be written |
| col_we | output | 8 | Column write strobes |
| col_bit_en | output | 256 | Bit enables, 32 per column |
| col_base | output | COL_W | Aligned base column of the access |
| wr_data | output | 32 | Data to write (color or bus data) |
| wr_reject | output | 1 | A too-early block write was refused |
| busy | output | 1 | Block-write cycle time still running |

## Verification
Strobes, enables, base, data and reject all follow the command after exactly one clock edge. `busy` changes at that same edge and stays high for TBWC-1 cycles. The driver applies each command at a falling edge and queues the values the requirements predict for the following edge. The monitor samples one time unit after each rising edge and compares those outputs against the queue head. The bench keeps its own counter for the cycle-time window, so each expected `busy` and reject is settled before the clock edge where the design produces it.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_WRITE = 2'd1,
    OP_LOAD  = 2'd2
  } op_e;

  localparam int unsigned BLK_COLS = 8;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned LO_W     = 3;
endpackage

// File: rtl/blkwr_color_reg.sv
module blkwr_color_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] color
);
  logic [DATA_W-1:0] color_d, color_q;

  always_comb begin
    color_d = color_q;
    if (load_en) color_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) color_q <= '0;
    else        color_q <= color_d;
  end

  assign color = color_q;

  // R2
  color_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (color == $past(load_data)));

  // R2
  color_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(color));
endmodule

// File: rtl/blkwr_pacer.sv
module blkwr_pacer #(
  parameter int unsigned TBWC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_req,
  output logic accept,
  output logic busy
);
  localparam int unsigned CNT_W = (TBWC < 2) ? 1 : $clog2(TBWC);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TBWC - 1);

  logic [CNT_W-1:0] cnt_d, cnt_q;

  assign busy   = (cnt_q != '0);
  assign accept = blk_req & ~busy;

  always_comb begin
    cnt_d = cnt_q;
    if (accept)     cnt_d = RELOAD;
    else if (busy)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (TBWC > 1) begin : g_window
      // R9
      busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    end else begin : g_nowindow
      // R9
      never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy);
    end
  endgenerate
endmodule

// File: rtl/blkwr_mask_gen.sv
module blkwr_mask_gen
  import blkwr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                       is_block,
  input  logic [LO_W-1:0]            col_lo,
  input  logic [DATA_W-1:0]          dq,
  input  logic [DATA_W/LANE_W-1:0]   byte_mask,
  input  logic                       wpb_on,
  input  logic [DATA_W-1:0]          bit_mask,
  output logic [BLK_COLS*DATA_W-1:0] bit_en
);
  localparam int unsigned NBYTE = DATA_W / LANE_W;

  for (genvar k = 0; k < BLK_COLS; k++) begin : g_col
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      logic sel;
      assign sel = is_block ? dq[b*LANE_W + k] : (col_lo == LO_W'(k));
      for (genvar j = 0; j < LANE_W; j++) begin : g_bit
        assign bit_en[k*DATA_W + b*LANE_W + j] =
          sel & ~byte_mask[b] & (~wpb_on | bit_mask[b*LANE_W + j]);
      end
    end
  end
endmodule

// File: rtl/blkwr_engine.sv
module blkwr_engine
  import blkwr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned TBWC   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 cmd_op,
  input  logic [COL_W-1:0]           col_addr,
  input  logic                       sfn,
  input  logic [DATA_W-1:0]          dq,
  input  logic [DATA_W/8-1:0]        byte_mask,
  input  logic                       wpb_on,
  input  logic [DATA_W-1:0]          bit_mask,
  output logic [7:0]                 col_we,
  output logic [8*DATA_W-1:0]        col_bit_en,
  output logic [COL_W-1:0]           col_base,
  output logic [DATA_W-1:0]          wr_data,
  output logic                       wr_reject,
  output logic                       busy
);
  localparam int unsigned EN_W = BLK_COLS * DATA_W;

  op_e op;
  logic is_wr, blk_req, norm_req, accept, issue;
  logic [DATA_W-1:0] color;
  logic [EN_W-1:0]   en_comb;

  assign op       = op_e'(cmd_op);
  assign is_wr    = (op == OP_WRITE);
  assign blk_req  = is_wr & sfn;
  assign norm_req = is_wr & ~sfn;

  blkwr_color_reg #(.DATA_W(DATA_W)) u_color (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (op == OP_LOAD),
    .load_data (dq),
    .color     (color)
  );

  blkwr_pacer #(.TBWC(TBWC)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .blk_req (blk_req),
    .accept  (accept),
    .busy    (busy)
  );

  blkwr_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .is_block  (sfn),
    .col_lo    (col_addr[LO_W-1:0]),
    .dq        (dq),
    .byte_mask (byte_mask),
    .wpb_on    (wpb_on),
    .bit_mask  (bit_mask),
    .bit_en    (en_comb)
  );

  assign issue = norm_req | accept;

  logic [EN_W-1:0]     en_d, en_q;
  logic [7:0]          we_d, we_q;
  logic [COL_W-1:0]    base_d, base_q;
  logic [DATA_W-1:0]   data_d, data_q;
  logic                rej_d, rej_q;

  always_comb begin
    en_d   = issue ? en_comb : '0;
    base_d = '0;
    data_d = '0;
    if (issue) begin
      base_d = {col_addr[COL_W-1:LO_W], {LO_W{1'b0}}};
      data_d = sfn ? color : dq;
    end
    rej_d = blk_req & ~accept;
    for (int k = 0; k < 8; k++) we_d[k] = |en_d[k*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      we_q   <= '0;
      base_q <= '0;
      data_q <= '0;
      rej_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      we_q   <= we_d;
      base_q <= base_d;
      data_q <= data_d;
      rej_q  <= rej_d;
    end
  end

  assign col_bit_en = en_q;
  assign col_we     = we_q;
  assign col_base   = base_q;
  assign wr_data    = data_q;
  assign wr_reject  = rej_q;

  // R9
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> (col_we == '0));

  // R9
  busy_block_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && blk_req) |=> wr_reject);

  // R10
  single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP) |=> (col_we == '0));

  // R7
  normal_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_req |=> $onehot0(col_we));

  // R4
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_we != '0) |-> (col_base[LO_W-1:0] == '0));
endmodule

// File: tb/blkwr_engine_tb.sv
module blkwr_engine_tb;
  localparam int DW = 32;
  localparam int CW = 9;
  localparam int TB = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cmd_op;
  logic [CW-1:0] col_addr;
  logic sfn, wpb_on;
  logic [DW-1:0] dq, bit_mask;
  logic [3:0] byte_mask;
  logic [7:0] col_we;
  logic [8*DW-1:0] col_bit_en;
  logic [CW-1:0] col_base;
  logic [DW-1:0] wr_data;
  logic wr_reject, busy;

  always #5 clk = ~clk;

  blkwr_engine #(.DATA_W(DW), .COL_W(CW), .TBWC(TB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .col_addr(col_addr), .sfn(sfn),
    .dq(dq), .byte_mask(byte_mask), .wpb_on(wpb_on), .bit_mask(bit_mask),
    .col_we(col_we), .col_bit_en(col_bit_en), .col_base(col_base),
    .wr_data(wr_data), .wr_reject(wr_reject), .busy(busy)
  );

  typedef struct {
    logic [7:0]      we;
    logic [8*DW-1:0] en;
    logic [CW-1:0]   base;
    logic [DW-1:0]   data;
    logic            rej;
    logic            bsy;
    string           tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic [DW-1:0] color_m = '0;
  int bcnt = 0;
  bit done = 0;

  function automatic logic [8*DW-1:0] model_en(bit blk, logic [2:0] lo, logic [DW-1:0] d,
                                               logic [3:0] bm, bit wpb, logic [DW-1:0] m);
    logic [8*DW-1:0] r = '0;
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < DW; i++) begin
        bit s;
        s = blk ? d[8*(i/8)+k] : (int'(lo) == k);
        r[k*DW+i] = s && !bm[i/8] && (!wpb || m[i]);
      end
    return r;
  endfunction

  task automatic drive(input logic [1:0] op, input bit s, input logic [CW-1:0] a,
                       input logic [DW-1:0] d, input logic [3:0] bm, input bit wpb,
                       input logic [DW-1:0] m, input string tag);
    exp_t e;
    bit was_busy, acc, iss;
    @(negedge clk);
    cmd_op = op; sfn = s; col_addr = a; dq = d; byte_mask = bm; wpb_on = wpb; bit_mask = m;
    was_busy = (bcnt > 0);
    acc = (op == 2'd1) && s && !was_busy;
    iss = acc || ((op == 2'd1) && !s);
    e.tag = tag;
    e.rej = (op == 2'd1) && s && was_busy;
    e.en = iss ? model_en(s, a[2:0], d, bm, wpb, m) : '0;
    for (int k = 0; k < 8; k++) e.we[k] = |e.en[k*DW +: DW];
    e.base = iss ? {a[CW-1:3], 3'b000} : '0;
    e.data = iss ? (s ? color_m : d) : '0;
    if (acc) bcnt = TB - 1;
    else if (bcnt > 0) bcnt--;
    e.bsy = (bcnt > 0);
    if (op == 2'd2) color_m = d;
    q.push_back(e);
  endtask

  task automatic nop(input string tag);
    drive(2'd0, 0, '0, '0, '0, 0, '0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (col_we !== e.we || col_bit_en !== e.en || col_base !== e.base ||
            wr_data !== e.data || wr_reject !== e.rej || busy !== e.bsy) begin
          errors++;
          $display("FAIL %s: we=%h base=%h data=%h rej=%b busy=%b en=%h | exp we=%h base=%h data=%h rej=%b busy=%b en=%h",
                   e.tag, col_we, col_base, wr_data, wr_reject, busy, col_bit_en,
                   e.we, e.base, e.data, e.rej, e.bsy, e.en);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; cmd_op = '0; sfn = 0; col_addr = '0; dq = '0;
    byte_mask = '0; wpb_on = 0; bit_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    // R1 reset state
    if (col_we !== '0 || col_bit_en !== '0 || col_base !== '0 || wr_data !== '0 ||
        wr_reject !== 1'b0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R1: we=%h base=%h data=%h rej=%b busy=%b exp all zero",
               col_we, col_base, wr_data, wr_reject, busy);
    end
    nop("R1 idle after reset");
    drive(2'd2, 0, '0, 32'hA5C3_0FF0, '0, 0, '0, "R2 load color");
    drive(2'd1, 1, 9'h01D, 32'h8040_2001, '0, 0, '0, "R3 R4 block write");
    drive(2'd1, 1, 9'h040, 32'hFFFF_FFFF, '0, 0, '0, "R9 early block rejected");
    nop("R10 no strobes after nop");
    drive(2'd1, 1, 9'h047, 32'hFFFF_FFFF, 4'b0101, 0, '0, "R5 byte mask");
    drive(2'd1, 0, 9'h0B5, 32'h1234_5678, '0, 0, '0, "R11 normal while busy");
    drive(2'd1, 1, 9'h100, 32'h0F0F_3C3C, '0, 1, 32'h00FF_F00F, "R6 wpb on");
    nop("R10 gap");
    drive(2'd1, 1, 9'h100, 32'h0F0F_3C3C, '0, 0, 32'h0000_0000, "R6 wpb off mask ignored");
    nop("R10 gap");
    drive(2'd1, 0, 9'h0D5, 32'hDEAD_BEEF, 4'b0010, 1, 32'hFF00_FF0F, "R7 normal write col 5");
    drive(2'd1, 1, 9'h008, 32'h0000_0000, '0, 0, '0, "R8 no column selected");
    drive(2'd1, 0, 9'h003, 32'h0000_00FF, 4'b1111, 0, '0, "R8 fully masked normal");
    drive(2'd2, 0, '0, 32'h1357_9BDF, '0, 0, '0, "R2 reload color");
    drive(2'd1, 1, 9'h1F8, 32'h0102_0408, '0, 0, '0, "R2 R3 new color used");
    drive(2'd1, 1, 9'h1F8, 32'hFFFF_FFFF, '0, 0, '0, "R9 reject back to back");
    drive(2'd1, 1, 9'h011, 32'h8000_0001, '0, 0, '0, "R9 accepted after cycle time");
    nop("R10 drain");
    nop("R10 drain");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule